// File: doc/BRIEF.md
# Big-Endian Store Lane Unit

This block turns one store request per clock into a registered word-wide write on a 32-bit bus with four per-byte write enables. A request carries an access size (byte, halfword or word), a byte address and the source register value. One clock later the block presents the write address, the source value moved onto the byte lanes the access covers, and a 4-bit enable that marks those lanes.

The bus has no separate write strobe: an enable of zero means the cycle carries no write. Lanes are assigned big-endian, so the lowest byte address within a word maps to the most significant lane. Stores may arrive on every cycle, and each one produces its write on the following cycle. Lanes that are not enabled carry data that the memory must ignore.

Top module: `store_lane_unit`

## Requirements
- R1: While reset is held and in the first cycles after it, the write enable is 0000, so no write is presented.
- R2: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. A word store presents enable 1111 and the whole source value unchanged, whatever the two low address bits are.
- R3: A halfword store whose address bit 1 is 0 presents enable 1100 and places source bits 15:0 in write-data bits 31:16. Address bit 0 is ignored.
- R4: A halfword store whose address bit 1 is 1 presents enable 0011 and places source bits 15:0 in write-data bits 15:0.
- R5: A byte store at byte offset k (address bits 1:0) presents only enable bit 3-k and places source bits 7:0 in that lane.
- R6: A cycle without a request presents enable 0000 on the following cycle.
- R7: A request with the reserved size code presents enable 0000 and writes nothing.
- R8: Each accepted request produces its write exactly one cycle later, and requests on consecutive cycles produce writes on consecutive cycles.
- R9: The write address equals the full 32-bit request address, low two bits included, for every write presented.
- R10: Enable bit i governs write-data bits 8i+7 to 8i: bit 0 the least significant byte and bit 3 the most significant byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | A store request is present this cycle |
| st_size_i | input | 2 | Access size code (00 byte, 01 halfword, 10 word, 11 reserved) |
| st_addr_i | input | 32 | Byte address of the store |
| st_data_i | input | 32 | Source register value, right-aligned |
| wr_addr_o | output | 32 | Registered write address |
| wr_data_o | output | 32 | Registered write data, steered onto the enabled lanes |
| wr_be_o | output | 4 | Registered per-byte write enable; 0000 means no write |

## Verification
The bench sends byte stores at all four offsets and halfword stores at all four offsets. A design with the little-endian lane order would enable the mirror lane, and a design that used address bit 0 for halfwords would enable a lane pair that is not aligned. Word stores at offsets other than zero catch a design that shifts the full word. Reserved size codes, idle gaps and back-to-back bursts catch writes that linger for an extra cycle, a design that treats the reserved code as a word, and a design that adds latency or drops every second request. Only enabled lanes are compared, and the checks use source values with distinct bytes, so data placed on the wrong lane shows up.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } st_size_e;
endpackage

// File: rtl/sbl_rst_sync.sv
module sbl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbl_lane_sel.sv
module sbl_lane_sel
  import sbl_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  st_size_e         size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LANES-1:0] be_o,
  output logic [OFF_W-1:0] shift_o
);
  // Big-endian: the lane for byte offset k is LANES-1-k.
  always_comb begin
    int nb;
    int base;
    int offv;
    int sh;
    offv = int'(off_i);
    unique case (size_i)
      SZ_BYTE: nb = 1;
      SZ_HALF: nb = (LANES >= 2) ? 2 : LANES;
      SZ_WORD: nb = LANES;
      default: nb = 0;
    endcase
    base = (nb == 0) ? 0 : (offv / nb) * nb;
    for (int l = 0; l < LANES; l++) begin
      int bo;
      bo = LANES - 1 - l;
      be_o[l] = (nb != 0) && (bo >= base) && (bo < base + nb);
    end
    sh = (nb == 0) ? 0 : (LANES - nb - base);
    shift_o = OFF_W'(sh);
  end
endmodule

// File: rtl/sbl_steer.sv
module sbl_steer #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0]    src_i,
  input  logic [OFF_W-1:0] shift_i,
  output logic [DW-1:0]    data_o
);
  // Lane l receives source byte (l - shift); lower lanes carry don't-care zeros.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      data_o[8*l +: 8] = 8'h00;
      for (int s = 0; s < LANES; s++) begin
        if (int'(shift_i) == s && l >= s) data_o[8*l +: 8] = src_i[8*(l-s) +: 8];
      end
    end
  end
endmodule

// File: rtl/sbl_wr_reg.sv
module sbl_wr_reg #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  localparam int DW = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [LANES-1:0]  be_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW-1:0]     data_o
);
  logic [LANES-1:0]  be_d, be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              load_en;

  always_comb begin
    be_d    = req_i ? be_i : '0;
    load_en = req_i && (|be_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) be_q <= '0;
    else        be_q <= be_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign be_o   = be_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  p_no_req_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (be_o == '0));
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (|be_i)) |=> (be_o == $past(be_i)) && (data_o == $past(data_i)));
endmodule

// File: rtl/store_lane_unit.sv
module store_lane_unit
  import sbl_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid_i,
  input  logic [1:0]        st_size_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DW-1:0]     st_data_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [LANES-1:0]  wr_be_o
);
  logic             rst_sync_n;
  st_size_e         size_s;
  logic [LANES-1:0] be_c;
  logic [OFF_W-1:0] shift_c;
  logic [DW-1:0]    data_c;

  assign size_s = st_size_e'(st_size_i);

  sbl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sbl_lane_sel #(.LANES(LANES)) u_sel (
    .size_i(size_s), .off_i(st_addr_i[OFF_W-1:0]), .be_o(be_c), .shift_o(shift_c));

  sbl_steer #(.LANES(LANES)) u_steer (
    .src_i(st_data_i), .shift_i(shift_c), .data_o(data_c));

  sbl_wr_reg #(.LANES(LANES), .ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .req_i(st_valid_i), .be_i(be_c),
    .addr_i(st_addr_i), .data_i(data_c),
    .be_o(wr_be_o), .addr_o(wr_addr_o), .data_o(wr_data_o));

  p_word_full_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_valid_i && st_size_i == 2'b10) |=> (wr_be_o == '1) && (wr_data_o == $past(st_data_i)));
  p_half_pair_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_valid_i && st_size_i == 2'b01) |=> ($countones(wr_be_o) == 2));
  p_byte_single_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_valid_i && st_size_i == 2'b00) |=> ($countones(wr_be_o) == 1));
  p_rsvd_idle_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_valid_i && st_size_i == 2'b11) |=> (wr_be_o == '0));
  p_addr_pass_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_valid_i && st_size_i != 2'b11) |=> (wr_addr_o == $past(st_addr_i)));
endmodule

// File: tb/store_lane_unit_tb_top.sv
module store_lane_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0]  be;
    logic [31:0] addr;
    logic [31:0] data;
    int          tag;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid_i;
  logic [1:0]  st_size_i;
  logic [31:0] st_addr_i, st_data_i;
  logic [31:0] wr_addr_o, wr_data_o;
  logic [3:0]  wr_be_o;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   done = 0;
  exp_t sb[$];
  logic [31:0] seed = 32'h1357_9bdf;

  store_lane_unit dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid_i(st_valid_i), .st_size_i(st_size_i),
    .st_addr_i(st_addr_i), .st_data_i(st_data_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] nextv();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Expected results written out per size and offset.
  function automatic exp_t model(logic [1:0] sz, logic [31:0] a, logic [31:0] d, string r);
    exp_t e;
    e.addr = a; e.data = 32'h0; e.req = r; e.tag = 0;
    case (sz)
      2'b10: begin e.be = 4'b1111; e.data = d; end
      2'b01: if (a[1]) begin e.be = 4'b0011; e.data[15:0] = d[15:0]; end
             else      begin e.be = 4'b1100; e.data[31:16] = d[15:0]; end
      2'b00: case (a[1:0])
               2'd0: begin e.be = 4'b1000; e.data[31:24] = d[7:0]; end
               2'd1: begin e.be = 4'b0100; e.data[23:16] = d[7:0]; end
               2'd2: begin e.be = 4'b0010; e.data[15:8]  = d[7:0]; end
               default: begin e.be = 4'b0001; e.data[7:0] = d[7:0]; end
             endcase
      default: e.be = 4'b0000;
    endcase
    return e;
  endfunction

  task automatic store(logic [1:0] sz, logic [31:0] a, logic [31:0] d, string r);
    exp_t e;
    @(posedge clk); #1;
    st_valid_i = 1'b1; st_size_i = sz; st_addr_i = a; st_data_i = d;
    e = model(sz, a, d, r);
    e.tag = cyc;
    sb.push_back(e);
  endtask

  task automatic idle(string r);
    exp_t e;
    @(posedge clk); #1;
    st_valid_i = 1'b0; st_size_i = 2'b10; st_addr_i = nextv(); st_data_i = nextv();
    e.be = 4'b0000; e.addr = 32'h0; e.data = 32'h0; e.req = r; e.tag = cyc;
    sb.push_back(e);
  endtask

  // Monitor: compare each item one cycle after it was driven.
  always @(negedge clk) begin
    if (sb.size() != 0 && sb[0].tag < cyc) begin
      exp_t e;
      logic [31:0] m;
      e = sb.pop_front();
      total++;
      if (cyc != e.tag + 1) begin
        bad++;
        $display("FAIL R8 latency: actual=%0d expected=%0d", cyc - e.tag, 1);
      end
      m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
      if (wr_be_o !== e.be) begin
        bad++;
        $display("FAIL %s enable: actual=%b expected=%b", e.req, wr_be_o, e.be);
      end else if (e.be != 4'b0000 && ((wr_data_o & m) !== (e.data & m))) begin
        bad++;
        $display("FAIL %s/R10 lane data: actual=%h expected=%h mask=%h", e.req, wr_data_o & m, e.data & m, m);
      end else if (e.be != 4'b0000 && wr_addr_o !== e.addr) begin
        bad++;
        $display("FAIL R9 address (%s): actual=%h expected=%h", e.req, wr_addr_o, e.addr);
      end
    end
  end

  initial begin
    st_valid_i = 1'b0; st_size_i = 2'b00; st_addr_i = '0; st_data_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (wr_be_o !== 4'b0000) begin bad++; $display("FAIL R1 in reset: actual=%b expected=0000", wr_be_o); end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    total++;
    if (wr_be_o !== 4'b0000) begin bad++; $display("FAIL R1 after reset: actual=%b expected=0000", wr_be_o); end

    // R2 word stores at every offset
    for (int k = 0; k < 4; k++) store(2'b10, 32'h0000_0700 + k, 32'h1234_5678 + k, "R2");
    // R3 / R4 halfword stores at every offset
    for (int k = 0; k < 4; k++) store(2'b01, 32'h0000_0800 + k, 32'hA1B2_C3D4, k < 2 ? "R3" : "R4");
    // R5 byte stores at every offset
    for (int k = 0; k < 4; k++) store(2'b00, 32'h0000_0900 + k, 32'h5566_7788 + k, "R5");
    // R6 idle gap, R7 reserved code
    idle("R6");
    store(2'b11, 32'h0000_0A00, 32'hDEAD_BEEF, "R7");
    idle("R6");
    store(2'b11, 32'h0000_0A03, 32'hFFFF_FFFF, "R7");
    // R8 back-to-back mixed burst with R9 address pass-through
    store(2'b00, 32'h0000_0801, 32'h0000_0034, "R8");
    store(2'b01, 32'h0000_0902, 32'h0000_1234, "R8");
    store(2'b10, 32'hFFFF_FFFF, 32'h0102_0304, "R9");
    idle("R6");
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = nextv();
      if (r[31:29] == 3'b000) idle("R6");
      else store(r[1:0], nextv(), nextv(), "R8");
    end
    idle("R6");
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (sb.size() != 0) begin
      bad++; total++;
      $display("FAIL R8 pending items: actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule